// File: doc/BRIEF.md
# Prefixed Half-Word Store Unit

This block is the store datapath for one half-word store instruction of a 32-bit processor that uses 16-bit instructions. Each cycle it decodes the current instruction word. A store instruction names a base register and carries a single immediate bit. A separate prefix instruction can load an 11-bit upper offset, which applies to the instruction that comes right after it. The block receives the base register value and the value of the fixed data register R0 from the register file. From these it drives a word-aligned address, 32-bit write data, per-byte enables and a write strobe to a simple synchronous memory port.

The immediate bit has two jobs. It picks which half of R0 is stored, and it picks which half of the addressed word receives that data. When a prefix is pending, its value is sign-extended, scaled by four and added to the base before the word is aligned. The pending prefix lasts for exactly one following valid instruction. Idle cycles do not consume it.

Top module: `hs_store_unit`

## Requirements
- R1: A store is an instruction with `instr_i[15:6] == 10'b0101101110` presented while `instr_valid_i` is high. In that cycle `wr_o` is 1. In every other cycle `wr_o` is 0.
- R2: With no pending prefix, `addr_o` equals `base_i` with bits 1:0 forced to zero.
- R3: When store bit `instr_i[5]` is 0, `be_o` is 4'b0011, `wdata_o[15:0]` is R0[15:0] and `wdata_o[31:16]` is zero.
- R4: When store bit `instr_i[5]` is 1, `be_o` is 4'b1100, `wdata_o[31:16]` is R0[31:16] and `wdata_o[15:0]` is zero.
- R5: A prefix is an instruction with `instr_i[15:11] == 5'b10011` while valid, and its offset is `instr_i[10:0]`. On the next valid instruction, a store uses the address (base + offset sign-extended and multiplied by 4) with bits 1:0 cleared.
- R6: A pending prefix is dropped by the next valid instruction, whether or not that instruction is a store. A following store then uses no offset.
- R7: After reset there is no pending prefix. A prefix presented while reset is asserted is not kept.
- R8: `base_idx_o` always equals the base register index `instr_i[4:0]`.
- R9: Cycles with `instr_valid_i` low leave a pending prefix intact. A second prefix replaces the first.
- R10: When `be_o` is 0 or a byte lane is disabled, that lane of `wdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| base_i | input | 32 | Value of the base register |
| r0_i | input | 32 | Value of register R0 |
| base_idx_o | output | 5 | Base register index for the register file |
| wr_o | output | 1 | Write strobe, one cycle per store |
| addr_o | output | 32 | Word-aligned memory address |
| be_o | output | 4 | Byte write enables |
| wdata_o | output | 32 | Write data, placed in the selected half |

## Verification
The hardest situation to reach is a prefix that survives idle bubbles but not an intervening instruction that is not a store. Reaching it needs a prefix, then one or more cycles with valid low, then either a store or an unrelated valid word. The driver builds exactly these sequences, with prefix values at the two signed extremes and a base whose low bits are nonzero. It then issues a store without a prefix, to prove the offset is gone.

// File: rtl/hs_store_pkg.sv
package hs_store_pkg;

    localparam int unsigned INSTR_W_DEF = 16;
    localparam int unsigned IDX_W_DEF   = 5;
    localparam int unsigned OFS_W_DEF   = 11;

    // store opcode occupies the bits above the select bit and the index
    localparam logic [9:0] STORE_OPC_DEF = 10'b0101101110;
    // prefix opcode occupies the bits above the offset field
    localparam logic [4:0] PFX_OPC_DEF   = 5'b10011;

    typedef enum logic [1:0] {
        OPK_OTHER  = 2'd0,
        OPK_STORE  = 2'd1,
        OPK_PREFIX = 2'd2
    } op_kind_e;

endpackage

// File: rtl/hs_decode.sv
module hs_decode
    import hs_store_pkg::*;
#(
    parameter int unsigned INSTR_W = INSTR_W_DEF,
    parameter int unsigned IDX_W   = IDX_W_DEF,
    parameter int unsigned OFS_W   = OFS_W_DEF,
    localparam int unsigned SOP_W  = INSTR_W - 1 - IDX_W,
    localparam int unsigned POP_W  = INSTR_W - OFS_W,
    parameter logic [SOP_W-1:0] STORE_OPC = STORE_OPC_DEF,
    parameter logic [POP_W-1:0] PFX_OPC   = PFX_OPC_DEF
) (
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output op_kind_e           kind_o,
    output logic               half_sel_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [OFS_W-1:0]   ofs_o
);

    always_comb begin
        kind_o     = OPK_OTHER;
        half_sel_o = instr_i[IDX_W];
        idx_o      = instr_i[IDX_W-1:0];
        ofs_o      = instr_i[OFS_W-1:0];
        if (valid_i) begin
            if (instr_i[INSTR_W-1 -: SOP_W] == STORE_OPC) begin
                kind_o = OPK_STORE;
            end else if (instr_i[INSTR_W-1 -: POP_W] == PFX_OPC) begin
                kind_o = OPK_PREFIX;
            end
        end
    end

endmodule

// File: rtl/hs_pfx_reg.sv
module hs_pfx_reg
    import hs_store_pkg::*;
#(
    parameter int unsigned OFS_W = OFS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  op_kind_e         kind_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic             pend_o,
    output logic [OFS_W-1:0] ofs_o
);

    typedef struct packed {
        logic             pend;
        logic [OFS_W-1:0] ofs;
    } pfx_state_t;

    pfx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            if (kind_i == OPK_PREFIX) begin
                st_d.pend = 1'b1;
                st_d.ofs  = ofs_i;
            end else begin
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign ofs_o  = st_q.ofs;

    AST_PFX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i != OPK_PREFIX) |=> !pend_o); // R6
    AST_PFX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(pend_o) && $stable(ofs_o))); // R9
    AST_PFX_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == OPK_PREFIX) |=> (pend_o && ofs_o == $past(ofs_i))); // R5

endmodule

// File: rtl/hs_addr_gen.sv
module hs_addr_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 11,
    parameter int unsigned ALN_W  = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              pend_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int unsigned EXT_W = ADDR_W - OFS_W - ALN_W;

    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        if (pend_i) begin
            disp = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i, {ALN_W{1'b0}}};
        end else begin
            disp = '0;
        end
        sum    = base_i + disp;
        addr_o = {sum[ADDR_W-1:ALN_W], {ALN_W{1'b0}}};
    end

    AST_ADDR_ALIGNED: assert final (addr_o[ALN_W-1:0] == '0); // R2

endmodule

// File: rtl/hs_lane_sel.sv
module hs_lane_sel #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic                half_sel_i,
    input  logic [DATA_W-1:0]   src_i,
    output logic [DATA_W/8-1:0] be_o,
    output logic [DATA_W-1:0]   data_o
);

    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned BE_W   = DATA_W / 8;
    localparam int unsigned BPH    = BE_W / 2;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic hit;
        assign hit = (half_sel_i == 1'(h));
        assign be_o[h*BPH +: BPH]      = {BPH{wr_i & hit}};
        assign data_o[h*HALF_W +: HALF_W] = (wr_i & hit) ? src_i[h*HALF_W +: HALF_W] : '0;
    end

    for (genvar b = 0; b < BE_W; b++) begin : g_byte_chk
        AST_DEAD_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !be_o[b] |-> (data_o[b*8 +: 8] == 8'h00)); // R10
    end

    AST_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> ($countones(be_o) == BPH*1 + BPH*0 + 0 + (BE_W/2 - BPH))); // R3
    AST_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |-> (be_o == '0)); // R1

endmodule

// File: rtl/hs_store_unit.sv
module hs_store_unit
    import hs_store_pkg::*;
#(
    parameter int unsigned INSTR_W = INSTR_W_DEF,
    parameter int unsigned IDX_W   = IDX_W_DEF,
    parameter int unsigned OFS_W   = OFS_W_DEF,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid_i,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [DATA_W-1:0]   r0_i,
    output logic [IDX_W-1:0]    base_idx_o,
    output logic                wr_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [DATA_W/8-1:0] be_o,
    output logic [DATA_W-1:0]   wdata_o
);

    localparam int unsigned ALN_W = $clog2(DATA_W / 8);

    op_kind_e         kind;
    logic             half_sel;
    logic [OFS_W-1:0] ofs_field;
    logic             pend;
    logic [OFS_W-1:0] ofs_held;

    hs_decode #(
        .INSTR_W (INSTR_W),
        .IDX_W   (IDX_W),
        .OFS_W   (OFS_W)
    ) u_decode (
        .valid_i    (instr_valid_i),
        .instr_i    (instr_i),
        .kind_o     (kind),
        .half_sel_o (half_sel),
        .idx_o      (base_idx_o),
        .ofs_o      (ofs_field)
    );

    hs_pfx_reg #(
        .OFS_W (OFS_W)
    ) u_pfx (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (instr_valid_i),
        .kind_i  (kind),
        .ofs_i   (ofs_field),
        .pend_o  (pend),
        .ofs_o   (ofs_held)
    );

    hs_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .ALN_W  (ALN_W)
    ) u_addr (
        .base_i (base_i),
        .pend_i (pend),
        .ofs_i  (ofs_held),
        .addr_o (addr_o)
    );

    assign wr_o = (kind == OPK_STORE);

    hs_lane_sel #(
        .DATA_W (DATA_W)
    ) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_o),
        .half_sel_i (half_sel),
        .src_i      (r0_i),
        .be_o       (be_o),
        .data_o     (wdata_o)
    );

    AST_NO_WR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid_i |-> !wr_o); // R1
    AST_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        base_idx_o == instr_i[IDX_W-1:0]); // R8
    AST_NOPFX_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && !$past(instr_valid_i && kind == OPK_PREFIX) && !pend)
        |-> (addr_o[ADDR_W-1:ALN_W] == base_i[ADDR_W-1:ALN_W])); // R2

endmodule

// File: tb/hs_store_unit_tb.sv
`timescale 1ns/1ps
module hs_store_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [31:0] base_i = '0;
    logic [31:0] r0_i = '0;
    logic [4:0]  base_idx_o;
    logic        wr_o;
    logic [31:0] addr_o;
    logic [3:0]  be_o;
    logic [31:0] wdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hs_store_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid_i (instr_valid_i),
        .instr_i       (instr_i),
        .base_i        (base_i),
        .r0_i          (r0_i),
        .base_idx_o    (base_idx_o),
        .wr_o          (wr_o),
        .addr_o        (addr_o),
        .be_o          (be_o),
        .wdata_o       (wdata_o)
    );

    typedef struct {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [4:0]  idx;
        bit          chk_addr;
        string       tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [15:0] st_ins(input logic sel, input logic [4:0] a);
        return {10'b0101101110, sel, a};
    endfunction

    function automatic logic [15:0] pf_ins(input logic [10:0] k);
        return {5'b10011, k};
    endfunction

    task automatic drive(input logic v, input logic [15:0] ins, input logic [31:0] b,
                         input logic [31:0] r0, input logic ewr, input logic [31:0] eaddr,
                         input logic [3:0] ebe, input logic [31:0] edata, input bit ca,
                         input string tag);
        exp_t e;
        @(negedge clk);
        instr_valid_i = v;
        instr_i       = ins;
        base_i        = b;
        r0_i          = r0;
        e.wr = ewr; e.addr = eaddr; e.be = ebe; e.data = edata;
        e.idx = ins[4:0]; e.chk_addr = ca; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one expected item per cycle, 1 ns after inputs change
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (wr_o !== e.wr || be_o !== e.be || wdata_o !== e.data ||
                    base_idx_o !== e.idx || (e.chk_addr && addr_o !== e.addr)) begin
                    errors++;
                    $display("FAIL %s: wr=%b be=%h data=%h idx=%0d addr=%h expected wr=%b be=%h data=%h idx=%0d addr=%h",
                             e.tag, wr_o, be_o, wdata_o, base_idx_o, addr_o,
                             e.wr, e.be, e.data, e.idx, e.addr);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] R0V = 32'hAABB_CCDD;

    initial begin
        // R7: prefix offered during reset must not be retained
        drive(1, pf_ins(11'd100), 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R7 prefix in reset");
        drive(0, 16'h0, 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R7 idle in reset");
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, st_ins(0, 5'd7), 32'h0000_0040, R0V, 1, 32'h0000_0040, 4'h3, 32'h0000_CCDD, 1, "R7 first store no offset");
        // R2 R3 R8: no prefix, low bits of base ignored, low half
        drive(1, st_ins(0, 5'd3), 32'h1000_0103, R0V, 1, 32'h1000_0100, 4'h3, 32'h0000_CCDD, 1, "R2 R3 imm0 no prefix");
        // R4: upper half
        drive(1, st_ins(1, 5'd31), 32'h1000_0103, R0V, 1, 32'h1000_0100, 4'hC, 32'hAABB_0000, 1, "R4 imm1 no prefix");
        // R1 R10: prefix itself writes nothing
        drive(1, pf_ins(11'd5), 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R1 prefix no write");
        // R5: positive offset with nonzero base low bits: 0x20000002+20 -> 0x20000014
        drive(1, st_ins(1, 5'd9), 32'h2000_0002, 32'h1234_5678, 1, 32'h2000_0014, 4'hC, 32'h1234_0000, 1, "R5 positive prefix");
        // R6: following store without prefix uses no offset
        drive(1, st_ins(0, 5'd9), 32'h2000_0002, 32'h1234_5678, 1, 32'h2000_0000, 4'h3, 32'h0000_5678, 1, "R6 prefix consumed");
        // R9 R5: offset -1 across idle bubbles
        drive(1, pf_ins(11'h7FF), 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R5 prefix -1");
        drive(0, st_ins(0, 5'd1), 32'h3000_0000, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R1 invalid store opcode");
        drive(0, 16'h0, 32'h3000_0000, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R9 idle");
        drive(1, st_ins(0, 5'd1), 32'h3000_0000, R0V, 1, 32'h2FFF_FFFC, 4'h3, 32'h0000_CCDD, 1, "R9 R5 prefix -1 after bubbles");
        // R5: most negative offset -1024 words
        drive(1, pf_ins(11'h400), 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R5 prefix min");
        drive(1, st_ins(1, 5'd2), 32'h0001_0000, R0V, 1, 32'h0000_F000, 4'hC, 32'hAABB_0000, 1, "R5 negative extreme");
        // R5: largest positive offset
        drive(1, pf_ins(11'h3FF), 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R5 prefix max");
        drive(1, st_ins(0, 5'd4), 32'h0000_0001, R0V, 1, 32'h0000_0FFC, 4'h3, 32'h0000_CCDD, 1, "R5 positive extreme");
        // R6: non-store valid instruction drops the prefix
        drive(1, pf_ins(11'd3), 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R6 prefix");
        drive(1, 16'h0000, 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R6 other instr");
        drive(1, st_ins(1, 5'd5), 32'h4000_0008, R0V, 1, 32'h4000_0008, 4'hC, 32'hAABB_0000, 1, "R6 offset dropped by other instr");
        // R9: second prefix replaces the first
        drive(1, pf_ins(11'd1), 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R9 prefix a");
        drive(1, pf_ins(11'd2), 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R9 prefix b");
        drive(1, st_ins(0, 5'd6), 32'h0000_0000, R0V, 1, 32'h0000_0008, 4'h3, 32'h0000_CCDD, 1, "R9 latest prefix wins");
        drive(0, 16'h0, 32'h0, R0V, 0, 32'h0, 4'h0, 32'h0, 0, "R10 idle lanes zero");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule